// File: doc/BRIEF.md
# Right Shift and Rotate Unit, 64-bit

This is a purely combinational execution unit for the right-shift and right-rotate group of a 64-bit load/store instruction set. It receives the function code, two small instruction fields and two register operands. It returns a 64-bit result and a flag that marks an illegal encoding.

A single function code can mean either a logical right shift or a right rotate. A spare 5-bit field in the instruction picks between the two. For the immediate forms that field is the rs field. For the variable forms it is the sa field.

Word forms work on the low 32 bits of the operand and sign-extend the 32-bit outcome. A separate doubleword function code adds 32 to the immediate amount, so immediate amounts from 32 to 63 can be reached. The unit only flags an illegal encoding. Trapping is handled elsewhere.

Top module: `shrot_unit`

## Requirements
- R1: Function codes 0x02 (word, immediate), 0x3A (doubleword, immediate) and 0x3E (doubleword, immediate plus 32) read `rs_fld`. A value of 0 gives a logical right shift that fills with zeros. A value of 1 gives a right rotate.
- R2: The word forms (0x02 and 0x06) use only `rt_val[31:0]`. Bit 31 of the 32-bit result is copied into `result[63:32]`, and `rt_val[63:32]` has no effect.
- R3: Code 0x3A shifts or rotates all 64 bits of `rt_val` right by `sa_fld` (0 to 31).
- R4: Code 0x3E uses `sa_fld + 32` as the amount (32 to 63).
- R5: The variable forms, 0x06 (word) and 0x16 (doubleword), read `sa_fld` as the selector: 0 means shift and 1 means rotate. The amount is `rs_val[4:0]` for the word form and `rs_val[5:0]` for the doubleword form. Higher bits of `rs_val` are ignored.
- R6: A rotate puts the bits that leave the low end back in at the high end. It wraps over 64 bits for doubleword forms and over 32 bits for word forms.
- R7: An amount of 0 passes the operand through unchanged, after sign extension for the word forms.
- R8: When the selector field of a group code is neither 0 nor 1, `illegal` is 1 and `result` is zero.
- R9: A function code outside the five listed gives `result` zero and `illegal` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_code | input | 6 | Function code of the instruction |
| rs_fld | input | 5 | rs instruction field; the shift/rotate selector for the immediate forms |
| sa_fld | input | 5 | sa instruction field; the amount for the immediate forms, the selector for the variable forms |
| rt_val | input | 64 | Operand to be shifted or rotated |
| rs_val | input | 64 | Register operand that holds the amount for the variable forms |
| result | output | 64 | Result of the operation |
| illegal | output | 1 | Selector field holds a value other than 0 or 1 |

## Verification
The hardest cases to reach are the ones where the selector lives in the sa field while the amount comes from `rs_val` with its upper bits set. A random register value rarely lines up with a chosen low-order amount, and a wrong mask would go unseen. The stimulus therefore sweeps every amount and puts random garbage into the masked-off bits of `rs_val` and into `rt_val[63:32]`. Operands with bit 31 or bit 63 set are used throughout, so that sign extension and rotate wrap both show up.

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int XLEN = 64
) (
  input  logic [5:0]      func_code,
  input  logic [4:0]      rs_fld,
  input  logic [4:0]      sa_fld,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] rs_val,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam int HALF = XLEN / 2;
  localparam int DAW  = $clog2(XLEN);
  localparam int WAW  = $clog2(HALF);

  localparam logic [5:0] FN_W_IMM   = 6'h02;
  localparam logic [5:0] FN_W_VAR   = 6'h06;
  localparam logic [5:0] FN_D_VAR   = 6'h16;
  localparam logic [5:0] FN_D_IMM   = 6'h3A;
  localparam logic [5:0] FN_D_IMM32 = 6'h3E;

  logic            in_grp, is_word, is_var;
  logic [4:0]      sel;
  logic [DAW-1:0]  amt;
  logic [HALF-1:0] w_src, w_shr, w_rot;
  logic [XLEN-1:0] d_shr, d_rot;
  logic [2*XLEN-1:0] d_dbl;
  logic [XLEN-1:0]   w_dbl;

  always_comb begin
    in_grp  = 1'b1;
    is_word = 1'b0;
    is_var  = 1'b0;
    amt     = '0;
    unique case (func_code)
      FN_W_IMM:   begin is_word = 1'b1; amt = DAW'(sa_fld); end
      FN_W_VAR:   begin is_word = 1'b1; is_var = 1'b1; amt = DAW'(rs_val[WAW-1:0]); end
      FN_D_IMM:   amt = DAW'(sa_fld);
      FN_D_IMM32: amt = DAW'(sa_fld) + DAW'(HALF);
      FN_D_VAR:   begin is_var = 1'b1; amt = rs_val[DAW-1:0]; end
      default:    in_grp = 1'b0;
    endcase
  end

  assign sel   = is_var ? sa_fld : rs_fld;
  assign w_src = rt_val[HALF-1:0];
  assign w_shr = w_src >> amt[WAW-1:0];
  assign w_dbl = {w_src, w_src} >> amt[WAW-1:0];
  assign w_rot = w_dbl[HALF-1:0];
  assign d_shr = rt_val >> amt;
  assign d_dbl = {rt_val, rt_val} >> amt;
  assign d_rot = d_dbl[XLEN-1:0];

  logic [HALF-1:0] w_out;
  logic [XLEN-1:0] d_out;
  assign w_out   = sel[0] ? w_rot : w_shr;
  assign d_out   = sel[0] ? d_rot : d_shr;
  assign illegal = in_grp && (sel > 5'd1);

  always_comb begin
    if (!in_grp || illegal)
      result = '0;
    else if (is_word)
      result = {{HALF{w_out[HALF-1]}}, w_out};
    else
      result = d_out;
  end

  always_comb begin
    if (illegal) p_illegal_zero_r8: assert (result == '0) else $error("illegal encoding left a nonzero result");
    if (!in_grp) p_outside_quiet_r9: assert (!illegal && result == '0) else $error("code outside the group was not quiet");
    if (in_grp && !illegal && is_word)
      p_word_sext_r2: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}) else $error("word result not sign-extended");
    if (in_grp && !illegal && !is_word && sel == 5'd0 && amt != '0)
      p_shift_zero_fill_r1: assert (!result[XLEN-1]) else $error("logical shift did not fill with zero");
    if (in_grp && !illegal && !is_word && amt == '0)
      p_zero_pass_r7: assert (result == rt_val) else $error("zero amount changed the operand");
  end
endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  func_code;
  logic [4:0]  rs_fld, sa_fld;
  logic [63:0] rt_val, rs_val, result;
  logic        illegal;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  shrot_unit u_shrot_unit (.func_code, .rs_fld, .sa_fld, .rt_val, .rs_val, .result, .illegal);

  function automatic logic [63:0] ref_op(input logic [63:0] x, input int n, input int w, input bit rot);
    logic [63:0] o = '0;
    for (int i = 0; i < w; i++) begin
      if (i + n < w) o[i] = x[i + n];
      else if (rot) o[i] = x[(i + n) - w];
    end
    if (w == 32) for (int i = 32; i < 64; i++) o[i] = o[31];
    return o;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic apply(input logic [5:0] f, input logic [4:0] r, input logic [4:0] s,
                       input logic [63:0] t, input logic [63:0] v);
    @(negedge clk);
    func_code = f; rs_fld = r; sa_fld = s; rt_val = t; rs_val = v;
    #5;
  endtask

  task automatic chk(input string req, input logic [63:0] exp_r, input logic exp_i);
    n_chk++;
    if (result !== exp_r || illegal !== exp_i) begin
      n_bad++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b", req, result, illegal, exp_r, exp_i);
    end
  endtask

  task automatic t_idle();
    apply(6'h00, 5'd0, 5'd0, 64'h0, 64'h0);
    chk("R9 idle", 64'h0, 1'b0);
    apply(6'h03, 5'd1, 5'd7, 64'hFFFF_0000_1234_5678, 64'h5);
    chk("R9 other code", 64'h0, 1'b0);
  endtask

  task automatic t_word_imm();
    for (int sel = 0; sel < 2; sel++)
      for (int a = 0; a < 32; a++) begin
        logic [63:0] t = rnd64();
        t[31] = a[0];
        apply(6'h02, 5'(sel), 5'(a), t, rnd64());
        chk(sel ? "R1 R2 R6 word rotate" : "R1 R2 word shift", ref_op(t, a, 32, sel[0]), 1'b0);
      end
  endtask

  task automatic t_dword_imm();
    for (int sel = 0; sel < 2; sel++)
      for (int a = 0; a < 32; a++) begin
        logic [63:0] t = rnd64() | 64'h8000_0000_0000_0001;
        apply(6'h3A, 5'(sel), 5'(a), t, rnd64());
        chk(sel ? "R3 R6 dword rotate" : "R3 dword shift", ref_op(t, a, 64, sel[0]), 1'b0);
      end
  endtask

  task automatic t_dword_imm32();
    for (int sel = 0; sel < 2; sel++)
      for (int a = 0; a < 32; a++) begin
        logic [63:0] t = rnd64() | 64'h8000_0000_0000_0000;
        apply(6'h3E, 5'(sel), 5'(a), t, rnd64());
        chk("R4 plus-32 form", ref_op(t, a + 32, 64, sel[0]), 1'b0);
      end
  endtask

  task automatic t_var();
    for (int sel = 0; sel < 2; sel++)
      for (int a = 0; a < 64; a++) begin
        logic [63:0] t = rnd64() | 64'h8000_0000_8000_0000;
        logic [63:0] v = (rnd64() & ~64'h3F) | 64'(a);
        apply(6'h16, 5'(sel), 5'(sel), t, v);
        chk("R5 dword variable", ref_op(t, a, 64, sel[0]), 1'b0);
        apply(6'h06, 5'd9, 5'(sel), t, v);
        chk("R5 word variable", ref_op(t, a % 32, 32, sel[0]), 1'b0);
      end
  endtask

  task automatic t_zero();
    apply(6'h3A, 5'd1, 5'd0, 64'hDEAD_BEEF_0123_4567, 64'h0);
    chk("R7 dword zero amount", 64'hDEAD_BEEF_0123_4567, 1'b0);
    apply(6'h02, 5'd0, 5'd0, 64'h0000_0000_8000_0001, 64'h0);
    chk("R7 word zero amount", 64'hFFFF_FFFF_8000_0001, 1'b0);
    apply(6'h02, 5'd1, 5'd4, 64'hFFFF_FFFF_0000_0001, 64'h0);
    chk("R6 word wrap", 64'h0000_0000_1000_0000, 1'b0);
  endtask

  task automatic t_illegal();
    for (int s = 2; s < 32; s += 5) begin
      apply(6'h3A, 5'(s), 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      chk("R8 imm selector", 64'h0, 1'b1);
      apply(6'h16, 5'd0, 5'(s), 64'hFFFF_FFFF_FFFF_FFFF, 64'h3);
      chk("R8 var selector", 64'h0, 1'b1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: result=%h illegal=%b expected completion", result, illegal);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_word_imm();
    t_dword_imm();
    t_dword_imm32();
    t_var();
    t_zero();
    t_illegal();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule